// File: doc/BRIEF.md
# Synthesizer reference and lock core

This block is the digital heart of an integer-N frequency synthesizer. A crystal-derived tick stream is divided down by one of three fixed reference ratios, picked with two select bits. An oscillator-derived tick stream is divided by a 15-bit programmable value. A two-flip-flop phase-frequency detector turns the two divided edges into up/down pump commands. A lock detector watches the phase error of each comparison and raises an in-lock flag once the loop has settled.

Both dividers run as clock enables inside one clock domain. Test codes can override the pump: switch it off, force a steady sink, or force a steady source. They can also replace the active-low lock indication on a shared pin with the reference waveform or with half the divided frequency. A separate bit turns the tuning output off, and a current-select bit passes straight through to the analog pump.

Top module: `synth_core`

## Requirements
- R1: The reference divider period, in `refTick` pulses, is 80 when `ratioSelB`=0 (any `ratioSelA`), 128 when `ratioSelA`=0 and `ratioSelB`=1, and 64 when both are 1.
- R2: The programmable divider period, in `vcoTick` pulses, equals `divN` taken as an unsigned value, for 1 to 32767.
- R3: A new ratio or `divN` is used only from the next terminal count of its divider, so the period already in progress completes at its old length.
- R4: A reference edge sets the up command and a divided edge sets the down command. When both are set, both clear on the next cycle, so up and down are never asserted together for two cycles running. With only reference edges arriving, `pumpUp` stays 1 and `pumpDn` stays 0.
- R5: `lockFlag` rises after 8 consecutive comparisons whose error is at most `lockWin` cycles. It falls after the first comparison whose error exceeds `lockWin`.
- R6: For test codes other than 100 and 101, `testPin` is the inverse of `lockFlag`: it is low when locked.
- R7: Test codes 010 and 011 hold `pumpUp` and `pumpDn` both at 0.
- R8: Test code 110 gives `pumpDn`=1 and `pumpUp`=0. Test code 111 gives `pumpUp`=1 and `pumpDn`=0.
- R9: Test code 100 puts on `testPin` a waveform whose period equals the reference divider period and which is high for half of it. Test code 101 puts on `testPin` a square wave with twice the divided period.
- R10: `tuneEn` is the inverse of `outOff`, and `pumpHiCur` follows `pumpHigh`.
- R11: While reset is held, `pumpUp`, `pumpDn` and `lockFlag` are 0 and `testPin` is 1 (for a normal test code).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | Crystal-derived count enable |
| vcoTick | input | 1 | Oscillator-derived count enable |
| ratioSelA | input | 1 | Reference ratio select, bit A |
| ratioSelB | input | 1 | Reference ratio select, bit B |
| divN | input | 15 | Programmable divide value |
| testCode | input | 3 | Test mode code |
| outOff | input | 1 | 1 turns the tuning output off (high impedance) |
| pumpHigh | input | 1 | 1 selects the high pump current |
| lockWin | input | 8 | Largest phase error, in cycles, accepted as in-window |
| pumpUp | output | 1 | Pump source command |
| pumpDn | output | 1 | Pump sink command |
| pumpHiCur | output | 1 | Pump current select to the analog pump |
| tuneEn | output | 1 | Tuning output enable |
| testPin | output | 1 | Active-low lock, or test waveform |
| lockFlag | output | 1 | In-lock flag |

## Verification
Assertions check on every cycle the behaviours that are fixed by the current inputs or by a single comparison event. These are the pump overrides for each test code, the lock-pin polarity in the normal codes, the one-cycle limit on simultaneous up and down, and the loss of lock after an out-of-window comparison. Only the bench's scenarios can show the properties that span many periods. These are the divider periods for each ratio and for random `divN` values, a ratio change that lands mid-period without shortening it, the exact number of comparisons before lock rises, the duty of the test waveform, and the loss of lock when the divided frequency drifts.

// File: rtl/synth_pkg.sv
package synth_pkg;
  localparam int REF_W = 8;

  typedef struct packed {
    logic             pumpOff;
    logic             forceSink;
    logic             forceSource;
    logic             showRef;
    logic             showDiv;
    logic [REF_W-1:0] refRatio;
  } synth_ctrl_t;
endpackage

// File: rtl/synth_cntdiv.sv
module synth_cntdiv #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic [W-1:0] reloadVal,
  output logic         term,
  output logic [W-1:0] cnt
);
  // counts down to zero; the reload value is sampled only at terminal count
  assign term = tick && (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cnt <= '0;
    else if (term)  cnt <= reloadVal;
    else if (tick)  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/synth_ctrl.sv
module synth_ctrl
  import synth_pkg::*;
#(
  parameter int WIN_W        = 8,
  parameter int ERR_W        = 16,
  parameter int LOCK_PERIODS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ratioSelA,
  input  logic             ratioSelB,
  input  logic [2:0]       testCode,
  input  logic [WIN_W-1:0] lockWin,
  input  logic             cmpDone,
  input  logic [ERR_W-1:0] cmpErr,
  output synth_ctrl_t      ctrl,
  output logic             lockFlag
);
  localparam int CNT_W = $clog2(LOCK_PERIODS + 1);

  logic [CNT_W-1:0] goodCnt;
  logic [ERR_W-1:0] winExt;
  logic             inWin;

  always_comb begin
    ctrl.pumpOff     = (testCode[2:1] == 2'b01);
    ctrl.forceSink   = (testCode == 3'b110);
    ctrl.forceSource = (testCode == 3'b111);
    ctrl.showRef     = (testCode == 3'b100);
    ctrl.showDiv     = (testCode == 3'b101);
    if (!ratioSelB)      ctrl.refRatio = REF_W'(80);
    else if (!ratioSelA) ctrl.refRatio = REF_W'(128);
    else                 ctrl.refRatio = REF_W'(64);
  end

  assign winExt = ERR_W'(lockWin);
  assign inWin  = (cmpErr <= winExt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) goodCnt <= '0;
    else if (cmpDone) begin
      if (!inWin)                              goodCnt <= '0;
      else if (goodCnt != CNT_W'(LOCK_PERIODS)) goodCnt <= goodCnt + 1'b1;
    end
  end

  assign lockFlag = (goodCnt == CNT_W'(LOCK_PERIODS));

  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (cmpDone && (cmpErr > winExt)) |=> !lockFlag);  // R5
  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockFlag) |-> $past(cmpDone));  // R5
endmodule

// File: rtl/synth_dpath.sv
module synth_dpath
  import synth_pkg::*;
#(
  parameter int N_W   = 15,
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic             vcoTick,
  input  logic [N_W-1:0]   divN,
  input  synth_ctrl_t      ctrl,
  input  logic             lockFlag,
  output logic             pumpUp,
  output logic             pumpDn,
  output logic             testPin,
  output logic             cmpDone,
  output logic [ERR_W-1:0] cmpErr
);
  logic             refTerm, divTerm;
  logic [REF_W-1:0] refCnt, curRatio;
  logic [N_W-1:0]   divCnt;
  logic             halfDiv, refWave;
  logic             upQ, dnQ, bothQ;
  logic [ERR_W-1:0] errCnt;

  synth_cntdiv #(.W(REF_W)) u_refDiv (
    .clk(clk), .rstN(rstN), .tick(refTick),
    .reloadVal(ctrl.refRatio - 1'b1), .term(refTerm), .cnt(refCnt)
  );

  synth_cntdiv #(.W(N_W)) u_progDiv (
    .clk(clk), .rstN(rstN), .tick(vcoTick),
    .reloadVal(divN - 1'b1), .term(divTerm), .cnt(divCnt)
  );

  // ratio in force for the running reference period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        curRatio <= '0;
    else if (refTerm) curRatio <= ctrl.refRatio;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        halfDiv <= 1'b0;
    else if (divTerm) halfDiv <= !halfDiv;
  end

  assign refWave = (refCnt >= (curRatio >> 1));

  // phase-frequency detector with common clear
  assign bothQ = upQ && dnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else if (bothQ) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else begin
      upQ <= upQ || refTerm;
      dnQ <= dnQ || divTerm;
    end
  end

  // phase error: cycles with exactly one side pending
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          errCnt <= '0;
    else if (bothQ)                     errCnt <= '0;
    else if ((upQ ^ dnQ) && !(&errCnt)) errCnt <= errCnt + 1'b1;
  end

  assign cmpDone = bothQ;
  assign cmpErr  = errCnt;

  always_comb begin
    pumpUp = upQ;
    pumpDn = dnQ;
    if (ctrl.pumpOff) begin
      pumpUp = 1'b0;
      pumpDn = 1'b0;
    end else if (ctrl.forceSink) begin
      pumpUp = 1'b0;
      pumpDn = 1'b1;
    end else if (ctrl.forceSource) begin
      pumpUp = 1'b1;
      pumpDn = 1'b0;
    end
  end

  always_comb begin
    if (ctrl.showRef)      testPin = refWave;
    else if (ctrl.showDiv) testPin = halfDiv;
    else                   testPin = !lockFlag;
  end

  AST_PFD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (upQ && dnQ) |=> !(upQ && dnQ));  // R4
endmodule

// File: rtl/synth_core.sv
module synth_core
  import synth_pkg::*;
#(
  parameter int N_W          = 15,
  parameter int WIN_W        = 8,
  parameter int ERR_W        = 16,
  parameter int LOCK_PERIODS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic             vcoTick,
  input  logic             ratioSelA,
  input  logic             ratioSelB,
  input  logic [N_W-1:0]   divN,
  input  logic [2:0]       testCode,
  input  logic             outOff,
  input  logic             pumpHigh,
  input  logic [WIN_W-1:0] lockWin,
  output logic             pumpUp,
  output logic             pumpDn,
  output logic             pumpHiCur,
  output logic             tuneEn,
  output logic             testPin,
  output logic             lockFlag
);
  synth_ctrl_t      ctrl;
  logic             cmpDone;
  logic [ERR_W-1:0] cmpErr;

  synth_ctrl #(.WIN_W(WIN_W), .ERR_W(ERR_W), .LOCK_PERIODS(LOCK_PERIODS)) u_ctrl (
    .clk(clk), .rstN(rstN), .ratioSelA(ratioSelA), .ratioSelB(ratioSelB),
    .testCode(testCode), .lockWin(lockWin), .cmpDone(cmpDone), .cmpErr(cmpErr),
    .ctrl(ctrl), .lockFlag(lockFlag)
  );

  synth_dpath #(.N_W(N_W), .ERR_W(ERR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .refTick(refTick), .vcoTick(vcoTick), .divN(divN),
    .ctrl(ctrl), .lockFlag(lockFlag), .pumpUp(pumpUp), .pumpDn(pumpDn),
    .testPin(testPin), .cmpDone(cmpDone), .cmpErr(cmpErr)
  );

  assign tuneEn    = !outOff;
  assign pumpHiCur = pumpHigh;

  AST_PUMP_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (testCode[2:1] == 2'b01) |-> (!pumpUp && !pumpDn));  // R7
  AST_FORCE_SINK: assert property (@(posedge clk) disable iff (!rstN)
    (testCode == 3'b110) |-> (pumpDn && !pumpUp));  // R8
  AST_FORCE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (testCode == 3'b111) |-> (pumpUp && !pumpDn));  // R8
  AST_LOCK_PIN: assert property (@(posedge clk) disable iff (!rstN)
    ((testCode != 3'b100) && (testCode != 3'b101)) |-> (testPin == !lockFlag));  // R6
endmodule

// File: tb/synth_core_bench.sv
module synth_core_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        refTick, vcoTick, ratioSelA, ratioSelB;
  logic [14:0] divN;
  logic [2:0]  testCode;
  logic        outOff, pumpHigh;
  logic [7:0]  lockWin;
  logic        pumpUp, pumpDn, pumpHiCur, tuneEn, testPin, lockFlag;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = !clk;

  synth_core u_synth_core (
    .clk(clk), .rstN(rstN), .refTick(refTick), .vcoTick(vcoTick),
    .ratioSelA(ratioSelA), .ratioSelB(ratioSelB), .divN(divN),
    .testCode(testCode), .outOff(outOff), .pumpHigh(pumpHigh), .lockWin(lockWin),
    .pumpUp(pumpUp), .pumpDn(pumpDn), .pumpHiCur(pumpHiCur), .tuneEn(tuneEn),
    .testPin(testPin), .lockFlag(lockFlag)
  );

  function automatic int expRatio(logic a, logic b);
    if (!b) return 80;
    if (!a) return 128;
    return 64;
  endfunction

  function automatic int expHalfDiv(int n);
    return 2 * n;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic waitRise();
    logic prev;
    do begin
      prev = testPin;
      @(negedge clk);
    end while (!(!prev && testPin));
  endtask

  // cycles between two successive rising edges of testPin
  task automatic measPeriod(output int p);
    logic prev;
    waitRise();
    p = 0;
    do begin
      prev = testPin;
      @(negedge clk);
      p++;
    end while (!(!prev && testPin));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p, c, hi, seed;
    seed = $urandom(1234);
    rstN = 1'b0; refTick = 1'b1; vcoTick = 1'b1;
    ratioSelA = 1'b1; ratioSelB = 1'b1; divN = 15'd64;
    testCode = 3'b000; outOff = 1'b0; pumpHigh = 1'b1; lockWin = 8'd3;
    repeat (3) @(negedge clk);
    check(!pumpUp && !pumpDn, "R11 pumps in reset", {pumpUp, pumpDn}, 0);
    check(!lockFlag && testPin, "R11 lock/pin in reset", {lockFlag, testPin}, 1);

    // R5: lock after 8 in-window comparisons, ratio 64 against N=64
    rstN = 1'b1;
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!lockFlag && c < 2000);
    check(c >= 448 && c <= 452, "R5 lock rise cycle", c, 450);
    check(testPin == 1'b0, "R6 lock pin low when locked", testPin, 0);

    // R5: drift pushes the error out of the window
    divN = 15'd65;
    repeat (700) @(negedge clk);
    check(!lockFlag, "R5 lock drops", lockFlag, 0);
    check(testPin == 1'b1, "R6 pin high when unlocked", testPin, 1);

    // R7 / R8 pump overrides
    testCode = 3'b010; @(negedge clk);
    check(!pumpUp && !pumpDn, "R7 code 010", {pumpUp, pumpDn}, 0);
    testCode = 3'b011; @(negedge clk);
    check(!pumpUp && !pumpDn, "R7 code 011", {pumpUp, pumpDn}, 0);
    testCode = 3'b110; @(negedge clk);
    check(pumpDn && !pumpUp, "R8 sink", {pumpUp, pumpDn}, 1);
    testCode = 3'b111; @(negedge clk);
    check(pumpUp && !pumpDn, "R8 source", {pumpUp, pumpDn}, 2);

    // R4: reference edges only
    testCode = 3'b000; vcoTick = 1'b0;
    repeat (300) @(negedge clk);
    check(pumpUp && !pumpDn, "R4 up only", {pumpUp, pumpDn}, 2);
    vcoTick = 1'b1;

    // R10
    outOff = 1'b1; pumpHigh = 1'b0; @(negedge clk);
    check(!tuneEn && !pumpHiCur, "R10 off/low", {tuneEn, pumpHiCur}, 0);
    outOff = 1'b0; pumpHigh = 1'b1; @(negedge clk);
    check(tuneEn && pumpHiCur, "R10 on/high", {tuneEn, pumpHiCur}, 3);

    // R1 all select combinations, R9 reference waveform
    testCode = 3'b100;
    for (int k = 0; k < 4; k++) begin
      ratioSelA = k[0]; ratioSelB = k[1];
      measPeriod(p); measPeriod(p);
      check(p == expRatio(k[0], k[1]), "R1 ref period", p, expRatio(k[0], k[1]));
    end
    ratioSelA = 1'b1; ratioSelB = 1'b1;
    measPeriod(p);
    hi = 0;
    for (int i = 0; i < 128; i++) begin
      hi += int'(testPin);
      @(negedge clk);
    end
    check(hi == 64, "R9 ref duty", hi, 64);

    // R3: ratio change mid-period keeps the running period whole
    ratioSelA = 1'b0; ratioSelB = 1'b0;
    measPeriod(p); measPeriod(p);
    c = 0;
    begin
      logic prev;
      do begin
        prev = testPin;
        if (c == 10) begin ratioSelA = 1'b0; ratioSelB = 1'b1; end
        @(negedge clk);
        c++;
      end while (!(!prev && testPin));
    end
    check(c == 80, "R3 old period kept", c, 80);
    measPeriod(p);
    check(p == 128, "R3 new period", p, 128);

    // R2 random divide values, R9 half divided frequency
    testCode = 3'b101;
    for (int k = 0; k < 6; k++) begin
      divN = 15'($urandom_range(299, 2));
      measPeriod(p); measPeriod(p); measPeriod(p);
      check(p == expHalfDiv(int'(divN)), "R2 R9 divided period", p, expHalfDiv(int'(divN)));
    end
    divN = 15'd1;
    measPeriod(p); measPeriod(p); measPeriod(p);
    check(p == 2, "R2 divide by one", p, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule